// File: doc/BRIEF.md
# Third-Order Bitstream Decimator

This block turns the one-bit stream of a sigma-delta modulator into signed 15-bit samples. It uses three integrators at the modulator rate, a decimate-by-32 phase counter and three differentiators at the output rate. Together they give a length-32 moving sum applied three times, so one sample comes out for every 32 accepted bits. A clock enable marks the cycles that carry a modulator bit. Cycles with the enable low do not advance the filter.

The raw filter result is scaled to 15 bits and clamped at the positive limit. It is then packed into a 16-bit word in one of three layouts:

- Sign-extended.
- Left-aligned, with a saturation code for positive full scale.
- Mixed, where the top bit is kept free as a control/data flag and reads 0 for data.

A small state machine marks the first three samples after reset as settling. Its states are ST_WARM0, ST_WARM1, ST_WARM2 and ST_STEADY. Each output pulse moves it ST_WARM0 -> ST_WARM1 -> ST_WARM2 -> ST_STEADY, and ST_STEADY holds on every later pulse. Reset returns it to ST_WARM0.

Top module: `cic3_decimator`

## Requirements
- R1: A bit of 1 enters the filter as +1 and a bit of 0 as -1. The raw result equals the response of [(1 - z^-32)/(1 - z^-1)]^3 from an all-zero state at reset. Output number n covers accepted bits 0 through 32n+31.
- R2: `out_valid` is high for exactly one cycle, the cycle after the clock edge that accepts every 32nd enabled bit. Cycles with `mod_ce` low neither count nor produce output.
- R3: The 15-bit value is the raw result shifted right arithmetically by one. If that exceeds 16383 it is clamped to 16383. A long run of ones gives 16383 and a long run of zeros gives -16384.
- R4: With `mode_left16` = 1 and `mode_mixed` = 0, the word is {value, 0}. The exception is a value of 16383, which gives 0x7FFF.
- R5: With `mode_mixed` = 1 (this overrides `mode_left16`), word bit 15 is 0 and bits 14:0 hold the value's 15 bits.
- R6: With both mode inputs 0, the word is the value sign-extended to 16 bits.
- R7: Synchronous reset clears all filter state. In the cycle after a reset edge, `out_valid`, `out_settling` and `out_word` are 0.
- R8: The first three output pulses after reset carry `out_settling` = 1. Every later pulse carries 0.
- R9: The mode inputs take effect at the edge that accepts the 32nd bit of a group. Their values during the rest of the group have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_ce | input | 1 | High in cycles that carry a modulator bit |
| mod_bit | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| mode_left16 | input | 1 | Selects the left-aligned 16-bit layout |
| mode_mixed | input | 1 | Selects the mixed layout with the free flag bit (overrides left16) |
| out_valid | output | 1 | One-cycle strobe with each new sample |
| out_word | output | 16 | Formatted sample word |
| out_settling | output | 1 | High on the first three strobes after reset |

## Verification
The positive clamp and the 0x7FFF saturation code are the hardest behaviour to reach from the ports. The raw result hits +32768 only after at least 94 consecutive ones have filled all three moving sums, and the phase of that run relative to the 32-bit groups also matters. The bench drives runs of 200 identical bits so that several consecutive outputs sit at full scale in each direction. It also mixes pseudo-random streams with idle cycles and mode changes in the middle of a group. Every output is compared against a direct convolution with the 94-tap impulse response, which the bench computes itself.

// File: rtl/cic3_pkg.sv
package cic3_pkg;

    // Warm-up tracking: one state per settling sample, then steady.
    typedef enum logic [1:0] {
        ST_WARM0  = 2'd0,
        ST_WARM1  = 2'd1,
        ST_WARM2  = 2'd2,
        ST_STEADY = 2'd3
    } warm_state_t;

    // Output word layout.
    typedef enum logic [1:0] {
        FMT_SIGNEXT = 2'd0,
        FMT_LEFT16  = 2'd1,
        FMT_MIXED   = 2'd2
    } fmt_sel_t;

    // The mixed layout takes priority over the left-aligned layout.
    function automatic fmt_sel_t fmt_decode(input logic left16, input logic mixed);
        if (mixed)  return FMT_MIXED;
        if (left16) return FMT_LEFT16;
        return FMT_SIGNEXT;
    endfunction

endpackage

// File: rtl/cic3_integrators.sv
module cic3_integrators #(
    parameter int ORDER = 3,
    parameter int W     = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] in_val,
    output logic [W-1:0] sum_next
);

    // Integrator registers and their next values. Wrap-around is intended.
    logic [W-1:0] acc_q [ORDER];
    logic [W-1:0] acc_d [ORDER];

    always_comb begin
        logic [W-1:0] run;
        run = in_val;
        for (int g = 0; g < ORDER; g++) begin
            run      = acc_q[g] + run;
            acc_d[g] = run;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < ORDER; g++) acc_q[g] <= '0;
        end else if (ce) begin
            for (int g = 0; g < ORDER; g++) acc_q[g] <= acc_d[g];
        end
    end

    // Last stage's new value, including the bit accepted this cycle.
    assign sum_next = acc_d[ORDER-1];

endmodule

// File: rtl/cic3_combs.sv
module cic3_combs #(
    parameter int ORDER = 3,
    parameter int W     = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  logic [W-1:0] in_val,
    output logic [W-1:0] result
);

    // Each differentiator holds one output-rate sample.
    logic [W-1:0] dly_q  [ORDER];
    logic [W-1:0] stage  [ORDER];

    always_comb begin
        logic [W-1:0] run;
        run = in_val;
        for (int g = 0; g < ORDER; g++) begin
            stage[g] = run;
            run      = run - dly_q[g];
        end
        result = run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < ORDER; g++) dly_q[g] <= '0;
        end else if (fire) begin
            for (int g = 0; g < ORDER; g++) dly_q[g] <= stage[g];
        end
    end

endmodule

// File: rtl/cic3_formatter.sv
module cic3_formatter
    import cic3_pkg::*;
#(
    parameter int W      = 17,
    parameter int OUT_W  = 15,
    parameter int WORD_W = 16,
    parameter int SHIFT  = 1
) (
    input  logic signed [W-1:0]      raw,
    input  logic                     sel_left16,
    input  logic                     sel_mixed,
    output logic        [WORD_W-1:0] word
);

    localparam int POS_I = (1 << (OUT_W - 1)) - 1;
    localparam int NEG_I = -(1 << (OUT_W - 1));
    localparam logic signed [W-1:0] POS_LIM = W'(POS_I);
    localparam logic signed [W-1:0] NEG_LIM = W'(NEG_I);
    localparam logic [WORD_W-1:0] SAT_WORD = {1'b0, {OUT_W{1'b1}}};

    logic signed [W-1:0] scaled;
    logic signed [W-1:0] clamped;
    logic [OUT_W-1:0]    value;
    fmt_sel_t            sel;

    always_comb begin
        scaled = raw >>> SHIFT;
        if (scaled > POS_LIM)      clamped = POS_LIM;
        else if (scaled < NEG_LIM) clamped = NEG_LIM;
        else                       clamped = scaled;
        value = clamped[OUT_W-1:0];
    end

    assign sel = fmt_decode(sel_left16, sel_mixed);

    always_comb begin
        unique case (sel)
            FMT_MIXED:  word = {1'b0, value};
            FMT_LEFT16: word = (clamped == POS_LIM) ? SAT_WORD : {value, 1'b0};
            default:    word = {value[OUT_W-1], value};
        endcase
    end

endmodule

// File: rtl/cic3_decimator.sv
module cic3_decimator
    import cic3_pkg::*;
#(
    parameter int ORDER  = 3,
    parameter int DECIM  = 32,
    parameter int OUT_W  = 15,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_ce,
    input  logic              mod_bit,
    input  logic              mode_left16,
    input  logic              mode_mixed,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_settling
);

    localparam int LOG2D = $clog2(DECIM);
    localparam int INT_W = ORDER * LOG2D + 2;
    localparam int SHIFT = ORDER * LOG2D + 1 - OUT_W;
    localparam int PH_W  = (LOG2D < 1) ? 1 : LOG2D;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DECIM - 1);
    localparam logic [INT_W-1:0] PLUS1  = INT_W'(1);
    localparam logic [INT_W-1:0] MINUS1 = '1;
    localparam logic [WORD_W-1:0] SAT_WORD = {1'b0, {(WORD_W-1){1'b1}}};

    logic [PH_W-1:0]   phase;
    logic              wrap;
    logic [INT_W-1:0]  in_val;
    logic [INT_W-1:0]  int_sum;
    logic [INT_W-1:0]  comb_out;
    logic [WORD_W-1:0] fmt_word;
    warm_state_t       state, state_nx;

    assign in_val = mod_bit ? PLUS1 : MINUS1;
    assign wrap   = mod_ce && (phase == PH_LAST);

    cic3_integrators #(.ORDER(ORDER), .W(INT_W)) u_int (
        .clk(clk), .rst(rst), .ce(mod_ce), .in_val(in_val), .sum_next(int_sum)
    );

    cic3_combs #(.ORDER(ORDER), .W(INT_W)) u_comb (
        .clk(clk), .rst(rst), .fire(wrap), .in_val(int_sum), .result(comb_out)
    );

    cic3_formatter #(.W(INT_W), .OUT_W(OUT_W), .WORD_W(WORD_W), .SHIFT(SHIFT)) u_fmt (
        .raw($signed(comb_out)), .sel_left16(mode_left16), .sel_mixed(mode_mixed),
        .word(fmt_word)
    );

    // Phase counter over accepted bits.
    always_ff @(posedge clk) begin
        if (rst)         phase <= '0;
        else if (wrap)   phase <= '0;
        else if (mod_ce) phase <= phase + PH_W'(1);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_WARM0;
        else     state <= state_nx;
    end

    // Warm-up transitions, taken on each output sample.
    always_comb begin
        state_nx = state;
        if (wrap) begin
            unique case (state)
                ST_WARM0:  state_nx = ST_WARM1;
                ST_WARM1:  state_nx = ST_WARM2;
                ST_WARM2:  state_nx = ST_STEADY;
                ST_STEADY: state_nx = ST_STEADY;
                default:   state_nx = ST_WARM0;
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_word     <= '0;
            out_settling <= 1'b0;
        end else begin
            out_valid    <= wrap;
            out_settling <= wrap && (state != ST_STEADY);
            if (wrap) out_word <= fmt_word;
        end
    end

    AST_PULSE_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(mod_ce)); // R2
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R2
    AST_MIXED_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mode_mixed)) |-> !out_word[WORD_W-1]); // R5
    AST_LEFT_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mode_left16 && !mode_mixed) && out_word != SAT_WORD)
        |-> !out_word[0]); // R4
    AST_SETTLE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_settling |-> out_valid); // R8
    AST_STEADY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STEADY) |=> (state == ST_STEADY)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_settling)); // R7

endmodule

// File: tb/cic3_decimator_tb.sv
module cic3_decimator_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_ce = 1'b0;
    logic        mod_bit = 1'b0;
    logic        mode_left16 = 1'b0;
    logic        mode_mixed = 1'b0;
    logic        out_valid;
    logic [15:0] out_word;
    logic        out_settling;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int pulses = 0;
    int xs [0:4095];
    int h [0:93];
    int b2 [0:62];
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    cic3_decimator u_dut (
        .clk(clk), .rst(rst), .mod_ce(mod_ce), .mod_bit(mod_bit),
        .mode_left16(mode_left16), .mode_mixed(mode_mixed),
        .out_valid(out_valid), .out_word(out_word), .out_settling(out_settling)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: direct convolution with the triple box response
    function automatic int model(input int m);
        int acc = 0;
        for (int k = 0; k < 94; k++)
            if (m - k >= 0) acc += h[k] * xs[m - k];
        return acc;
    endfunction

    // R3..R6: scale, clamp and layout
    function automatic logic [15:0] fmt(input int y, input logic l16, input logic mix);
        logic signed [31:0] v;
        v = y >>> 1;
        if (v > 16383) v = 16383;
        if (mix) return {1'b0, v[14:0]};
        if (l16) return (v == 16383) ? 16'h7FFF : {v[14:0], 1'b0};
        return v[15:0];
    endfunction

    function automatic string tag_for(input logic l16, input logic mix);
        if (mix) return "R1/R3/R5 word";
        if (l16) return "R1/R3/R4 word";
        return "R1/R3/R6 word";
    endfunction

    task automatic step(input logic ce, input logic b);
        logic exp_v;
        int y;
        @(negedge clk);
        mod_ce = ce;
        mod_bit = b;
        @(posedge clk);
        #1;
        exp_v = 1'b0;
        if (ce) begin
            xs[n] = b ? 1 : -1;
            n++;
            exp_v = (n % 32 == 0);
        end
        chk("R2 valid", {31'd0, out_valid}, {31'd0, exp_v});
        if (exp_v) begin
            y = model(n - 1);
            // R9: the modes in force at the 32nd bit decide the layout
            chk(tag_for(mode_left16, mode_mixed), {16'd0, out_word},
                {16'd0, fmt(y, mode_left16, mode_mixed)});
            chk("R8 settling", {31'd0, out_settling}, {31'd0, (pulses < 3)});
            pulses++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mod_ce = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R7 valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R7 settling after reset", {31'd0, out_settling}, 32'd0);
        chk("R7 word after reset", {16'd0, out_word}, 32'd0);
        n = 0;
        pulses = 0;
    endtask

    task automatic lfsr_adv();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        for (int k = 0; k < 63; k++) b2[k] = ((k < 62 - k) ? k : 62 - k) + 1;
        for (int k = 0; k < 94; k++) begin
            h[k] = 0;
            for (int j = k - 31; j <= k; j++)
                if (j >= 0 && j < 63) h[k] += b2[j];
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int acc;
        repeat (3) @(posedge clk);
        do_reset();

        // R4 with R3 saturation: long ones, then long zeros
        mode_left16 = 1'b1;
        mode_mixed = 1'b0;
        for (int i = 0; i < 200; i++) step(1'b1, 1'b1);
        chk("R4 full scale code", {16'd0, out_word}, 32'h7FFF);
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0);
        chk("R4 negative full scale", {16'd0, out_word}, 32'h8000);
        for (int i = 0; i < 160; i++) step(1'b1, i[0]);

        // R5: mixed overrides left16
        do_reset();
        mode_mixed = 1'b1;
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0);
        chk("R5 mixed negative full scale", {16'd0, out_word}, 32'h4000);
        for (int i = 0; i < 200; i++) step(1'b1, 1'b1);
        chk("R5 mixed positive full scale", {16'd0, out_word}, 32'h3FFF);

        // R6 and R9: pseudo-random bits, idle gaps, modes hopping mid-group
        do_reset();
        mode_left16 = 1'b0;
        mode_mixed = 1'b0;
        for (int i = 0; i < 1200; i++) begin
            lfsr_adv();
            if (lfsr[3:0] == 4'd0) step(1'b0, lfsr[7]);
            if (i % 7 == 3) begin
                mode_left16 = lfsr[9];
                mode_mixed = lfsr[11] & lfsr[5];
            end
            step(1'b1, lfsr[0]);
        end

        // R7: reset mid-group clears history
        for (int i = 0; i < 50; i++) begin
            lfsr_adv();
            step(1'b1, lfsr[0]);
        end
        do_reset();

        // first-order modulator on a slow ramp, modes hopping
        acc = 0;
        for (int i = 0; i < 1500; i++) begin
            int target;
            target = (i * 2000) / 1500 - 1000;
            if (acc >= 0) begin
                acc += target - 1000;
                step(1'b1, 1'b1);
            end else begin
                acc += target + 1000;
                step(1'b1, 1'b0);
            end
            if (i % 11 == 5) begin
                lfsr_adv();
                mode_left16 = lfsr[2];
                mode_mixed = lfsr[6];
            end
            if (i % 13 == 0) step(1'b0, 1'b1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule